// File: doc/BRIEF.md
# Byte-Lane Write Strobe Tester

This engine checks that every byte enable of a 32-bit memory changes only the byte it is meant to change. The memory is divided into regions placed every 4 MiB from a fixed base address. In each region the engine runs four lane trials, lanes 0 to 3 in order. A trial writes a fixed signature word to the region base and the inverse of that word to the next word. It then writes one byte into the base word with a single enable set, reads the neighbouring word and then the base word, and compares the base word with the value a healthy memory would hold.

When all four lanes of a region have been tried, any mismatch ends the run. The result then carries the region base address with a lane-failure mask in its four low bits. If every region passes, the run ends with a zero result. A caller pulses `start` with the memory size applied and waits for `done`. The memory answers each read with data on the cycle after the request.

Top module: `byte_lane_tester`

## Requirements
- R1: After reset, `done`, `fail` and `result` are 0 and `mem_req` is low.
- R2: Each lane trial starts with a full-word write (`mem_be` = 4'b1111) of 0xAABBCCDD to the region base, followed by a full-word write of 0x55443322 to base+4.
- R3: The third access of a trial writes the base address with only enable bit L set, where L is the lane index. The write data holds L in byte L (bits 8L+7:8L) and zero in every other byte.
- R4: The trial then reads base+4 and then the base address. Read data is taken from `mem_rdata` one cycle after the read request.
- R5: Lane L is marked failed when the base word read back differs from 0xAABBCCDD with byte L replaced by the value L.
- R6: Lanes are tried in the order 0, 1, 2, 3, and the signature and its inverse are written again before every lane.
- R7: If any lane of a region fails, the engine stops after that region. It then holds `done`=1 and `fail`=1 with `result` equal to the region base ORed with the 4-bit lane mask (bit L means lane L failed), and makes no further memory accesses.
- R8: Region bases are MEM_BASE + k·0x400000. The first region is always tested, and region k>0 is tested only if k·0x400000 < `mem_size`.
- R9: When all tested regions pass, the engine holds `done`=1, `fail`=0 and `result`=0.
- R10: `start` is accepted only while idle or done, and it starts a new run from the first region. While a run is in progress, `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle or done) |
| mem_size | input | ADDR_W | Memory size in bytes, latched at start |
| done | output | 1 | Run finished (held until the next start) |
| fail | output | 1 | Run found at least one faulty lane |
| result | output | ADDR_W | Failing region base ORed with lane mask, or 0 |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench checks the region count at the size boundaries. At a size of zero, one region must still be tested. At exactly 4 MiB there is one region, and a faulty second region must go unseen. At 5 MiB there are two regions. A design with an off-by-one limit would test one region too many or too few, and the access stream would show it. Faults are injected by dropping byte writes in chosen lanes, one lane or several at once. A design that indexed the mask wrongly, or that stopped before finishing the region, would return a wrong mask or base. A `start` pulse in the middle of a run checks that a busy engine does not restart, which would show up as a repeated region 0 in the access stream.

// File: rtl/bst_pkg.sv
package bst_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam logic [DATA_W-1:0] SIGNATURE = 32'hAABB_CCDD;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [3:0] {
        S_IDLE, S_WSIG, S_WINV, S_WBYTE, S_RINV, S_RBASE, S_CHECK, S_EVAL, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] { SRC_SIG, SRC_INV, SRC_LANE, SRC_NONE } wsrc_e;

    typedef struct packed {
        logic             req;
        logic             we;
        logic [LANES-1:0] be;
        logic             hi_word;
        wsrc_e            src;
    } mem_op_t;

    function automatic logic [DATA_W-1:0] lane_data(input lane_t lane);
        logic [DATA_W-1:0] v;
        v = DATA_W'(lane);
        return v << (8 * lane);
    endfunction

    function automatic logic [DATA_W-1:0] expect_word(input lane_t lane);
        logic [DATA_W-1:0] keep;
        keep = ~(DATA_W'(8'hFF) << (8 * lane));
        return (SIGNATURE & keep) | lane_data(lane);
    endfunction

    function automatic logic [LANES-1:0] lane_be(input lane_t lane);
        return LANES'(1) << lane;
    endfunction
endpackage

// File: rtl/bst_region.sv
module bst_region #(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE = '0,
    parameter int unsigned REGION_SHIFT = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] mem_size,
    output logic [ADDR_W-1:0] base,
    output logic              last
);
    localparam logic [ADDR_W:0] STRIDE = (ADDR_W + 1)'(1) << REGION_SHIFT;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W:0]   limit_q;
    logic [ADDR_W:0]   next_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= MEM_BASE;
            limit_q <= '0;
        end else if (load) begin
            base_q  <= MEM_BASE;
            limit_q <= {1'b0, MEM_BASE} + {1'b0, mem_size};
        end else if (step) begin
            base_q  <= base_q + STRIDE[ADDR_W-1:0];
        end
    end

    assign next_w = {1'b0, base_q} + STRIDE;
    assign last   = (next_w >= limit_q);
    assign base   = base_q;

    // R8: a step only ever lands on a base still inside the memory
    p_step_inside_r8: assert property (@(posedge clk) disable iff (rst)
        step |=> ({1'b0, base_q} < limit_q));
endmodule

// File: rtl/bst_lane_check.sv
module bst_lane_check
    import bst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              check_en,
    input  lane_t             lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  mask
);
    logic [LANES-1:0] mask_q;
    logic             mismatch;

    assign mismatch = (rdata != expect_word(lane));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask_q <= '0;
        end else if (check_en && mismatch) begin
            mask_q[lane] <= 1'b1;
        end
    end

    assign mask = mask_q;

    // R5: the mask moves only on a compare cycle or a clear
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear && !check_en) |=> $stable(mask_q));
endmodule

// File: rtl/bst_seq.sv
module bst_seq
    import bst_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic              region_last,
    input  logic [LANES-1:0]  mask,
    output logic              load,
    output logic              step,
    output logic              clear,
    output logic              check_en,
    output lane_t             lane,
    output mem_op_t           op,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] result
);
    seq_state_e        state_q;
    lane_t             lane_q;
    logic              done_q;
    logic              fail_q;
    logic [ADDR_W-1:0] result_q;
    logic              accept;

    assign accept   = start && (state_q == S_IDLE || state_q == S_DONE);
    assign load     = accept;
    assign clear    = accept || (state_q == S_EVAL);
    assign check_en = (state_q == S_CHECK);
    assign step     = (state_q == S_EVAL) && (mask == '0) && !region_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            lane_q   <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE, S_DONE: if (accept) begin
                    state_q  <= S_WSIG;
                    lane_q   <= '0;
                    done_q   <= 1'b0;
                    fail_q   <= 1'b0;
                    result_q <= '0;
                end
                S_WSIG:  state_q <= S_WINV;
                S_WINV:  state_q <= S_WBYTE;
                S_WBYTE: state_q <= S_RINV;
                S_RINV:  state_q <= S_RBASE;
                S_RBASE: state_q <= S_CHECK;
                S_CHECK: begin
                    if (lane_q == lane_t'(LANES - 1)) begin
                        state_q <= S_EVAL;
                    end else begin
                        lane_q  <= lane_q + 1'b1;
                        state_q <= S_WSIG;
                    end
                end
                S_EVAL: begin
                    lane_q <= '0;
                    if (mask != '0) begin
                        state_q  <= S_DONE;
                        done_q   <= 1'b1;
                        fail_q   <= 1'b1;
                        result_q <= base | ADDR_W'(mask);
                    end else if (region_last) begin
                        state_q  <= S_DONE;
                        done_q   <= 1'b1;
                    end else begin
                        state_q  <= S_WSIG;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        op = '{req: 1'b0, we: 1'b0, be: '0, hi_word: 1'b0, src: SRC_NONE};
        unique case (state_q)
            S_WSIG:  op = '{req: 1'b1, we: 1'b1, be: '1, hi_word: 1'b0, src: SRC_SIG};
            S_WINV:  op = '{req: 1'b1, we: 1'b1, be: '1, hi_word: 1'b1, src: SRC_INV};
            S_WBYTE: op = '{req: 1'b1, we: 1'b1, be: lane_be(lane_q), hi_word: 1'b0, src: SRC_LANE};
            S_RINV:  op = '{req: 1'b1, we: 1'b0, be: '0, hi_word: 1'b1, src: SRC_NONE};
            S_RBASE: op = '{req: 1'b1, we: 1'b0, be: '0, hi_word: 1'b0, src: SRC_NONE};
            default: ;
        endcase
    end

    assign lane   = lane_q;
    assign done   = done_q;
    assign fail   = fail_q;
    assign result = result_q;

    // R3: a write carries either every enable or exactly one
    p_be_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (op.req && op.we) |-> (op.be == '1 || $countones(op.be) == 1));
    // R7: no memory traffic once finished
    p_quiet_done_r7: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !op.req);
    // R7: a failing result always carries a nonzero lane mask
    p_fail_mask_r7: assert property (@(posedge clk) disable iff (rst)
        fail_q |-> (done_q && result_q[LANES-1:0] != '0));
    // R9: a passing run reports zero
    p_pass_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (done_q && !fail_q) |-> (result_q == '0));
    // R10: a busy engine keeps running when start is raised
    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start && state_q == S_WINV) |=> (state_q == S_WBYTE));
endmodule

// File: rtl/byte_lane_tester.sv
module byte_lane_tester
    import bst_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h1000_0000,
    parameter int unsigned REGION_SHIFT = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] mem_size,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] result,
    output logic              mem_req,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned WORD_BYTES = DATA_W / 8;

    logic              load, step, clear, check_en, region_last;
    logic [ADDR_W-1:0] base;
    logic [LANES-1:0]  mask;
    lane_t             lane;
    mem_op_t           op;

    bst_region #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .REGION_SHIFT(REGION_SHIFT)) u_region (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .mem_size(mem_size), .base(base), .last(region_last)
    );

    bst_lane_check u_check (
        .clk(clk), .rst(rst), .clear(clear), .check_en(check_en),
        .lane(lane), .rdata(mem_rdata), .mask(mask)
    );

    bst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .base(base),
        .region_last(region_last), .mask(mask),
        .load(load), .step(step), .clear(clear), .check_en(check_en),
        .lane(lane), .op(op), .done(done), .fail(fail), .result(result)
    );

    always_comb begin
        unique case (op.src)
            SRC_SIG:  mem_wdata = SIGNATURE;
            SRC_INV:  mem_wdata = ~SIGNATURE;
            SRC_LANE: mem_wdata = lane_data(lane);
            default:  mem_wdata = '0;
        endcase
    end

    assign mem_req  = op.req;
    assign mem_we   = op.we;
    assign mem_be   = op.be;
    assign mem_addr = op.hi_word ? base + ADDR_W'(WORD_BYTES) : base;
endmodule

// File: tb/byte_lane_tester_test.sv
module byte_lane_tester_test;
    localparam logic [31:0] BASE   = 32'h1000_0000;
    localparam logic [31:0] STRIDE = 32'h0040_0000;

    typedef struct {
        bit          we;
        logic [3:0]  be;
        logic [31:0] addr;
        logic [31:0] wdata;
    } acc_t;

    typedef struct {
        bit          fail;
        logic [31:0] result;
    } res_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] mem_size = '0;
    logic        done, fail;
    logic [31:0] result;
    logic        mem_req, mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    acc_t acc_q[$];
    res_t res_q[$];
    logic [31:0] mem [logic [31:0]];
    int          flt_region = -1;
    logic [3:0]  flt_mask = '0;
    logic        done_prev = 1'b0;

    always #4 clk = ~clk;

    byte_lane_tester uut (
        .clk(clk), .rst(rst), .start(start), .mem_size(mem_size),
        .done(done), .fail(fail), .result(result),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with injected dropped byte lanes in one region
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                logic [31:0] w;
                bit drop;
                w = mem.exists(mem_addr) ? mem[mem_addr] : '0;
                drop = (mem_be != 4'hF) && (flt_region >= 0) &&
                       (((mem_addr - BASE) >> 22) == 32'(flt_region)) &&
                       ((mem_be & flt_mask) != 0);
                for (int b = 0; b < 4; b++)
                    if (mem_be[b] && !drop) w[8*b +: 8] = mem_wdata[8*b +: 8];
                mem[mem_addr] = w;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : '0;
            end
        end
    end

    // monitor: access stream and results
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) begin
                if (acc_q.size() == 0) begin
                    check(0, "R7 unexpected access", mem_addr, 32'h0);
                end else begin
                    acc_t e;
                    e = acc_q.pop_front();
                    check(mem_we == e.we, "R4 access kind", 32'(mem_we), 32'(e.we));
                    check(mem_addr == e.addr, "R8 access address", mem_addr, e.addr);
                    if (e.we) begin
                        check(mem_be == e.be, "R3 byte enables", 32'(mem_be), 32'(e.be));
                        check(mem_wdata == e.wdata, "R2 write data", mem_wdata, e.wdata);
                    end
                end
            end
            if (done && !done_prev) begin
                if (res_q.size() == 0) begin
                    check(0, "R10 unexpected completion", result, 32'h0);
                end else begin
                    res_t r;
                    r = res_q.pop_front();
                    check(fail == r.fail, "R9 fail flag", 32'(fail), 32'(r.fail));
                    check(result == r.result, "R7 result", result, r.result);
                    check(acc_q.size() == 0, "R6 accesses pending at done", 32'(acc_q.size()), 32'h0);
                end
            end
            done_prev <= done;
        end
    end

    // driver: pushes the expected access stream and result, then starts
    task automatic run(input logic [31:0] size, input int freg, input logic [3:0] fmask, input bit poke);
        int nreg;
        res_t r;
        nreg = (size == 0) ? 1 : int'((size + STRIDE - 1) / STRIDE);
        r.fail = 0; r.result = '0;
        for (int k = 0; k < nreg && !r.fail; k++) begin
            logic [31:0] b;
            logic [3:0]  m;
            b = BASE + 32'(k) * STRIDE;
            m = (k == freg) ? fmask : 4'h0;
            for (int l = 0; l < 4; l++) begin
                acc_q.push_back('{1, 4'hF, b, 32'hAABB_CCDD});
                acc_q.push_back('{1, 4'hF, b + 4, 32'h5544_3322});
                acc_q.push_back('{1, 4'(1 << l), b, 32'(l) << (8 * l)});
                acc_q.push_back('{0, 4'h0, b + 4, 32'h0});
                acc_q.push_back('{0, 4'h0, b, 32'h0});
            end
            if (m != 0) begin r.fail = 1; r.result = b | 32'(m); end
        end
        res_q.push_back(r);
        flt_region = freg;
        flt_mask   = fmask;
        mem_size   = size;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (9) @(negedge clk);
            start = 1'b1;          // R10: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        begin
            int t = 0;
            while (res_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(done == 0, "R1 done", 32'(done), 0);
        check(fail == 0, "R1 fail", 32'(fail), 0);
        check(result == 0, "R1 result", result, 0);
        check(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);

        run(32'h0080_0000, -1, 4'h0, 0);   // R2 R3 R4 R6 R9: two clean regions
        run(32'h0050_0000, 1, 4'b0100, 0); // R5 R7: lane 2 dead in second region
        run(32'h0000_0000, -1, 4'h0, 0);   // R8: zero size still tests one region
        run(32'h00C0_0000, 0, 4'b1001, 0); // R5 R7: two lanes dead in first region
        run(32'h0040_0000, 1, 4'hF, 0);    // R8: exact 4 MiB, faulty region never reached
        run(32'h0100_0000, 3, 4'b0010, 1); // R10: mid-run start ignored
        run(32'h0400_0000, -1, 4'h0, 0);   // R8 R9: sixteen clean regions

        check(acc_q.size() == 0 && res_q.size() == 0, "R10 stream drained",
              32'(acc_q.size() + res_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule